// File: doc/BRIEF.md
# DMA Channel Address Stepper

This unit holds one DMA channel's current address and remaining beat count, and advances both each time the transfer engine reports a finished beat. The address moves by one byte for a narrow (8-bit) beat or two bytes for a wide (16-bit) beat. It moves up or down according to the channel's direction mode.

Two controls shape the new address. When wrap confinement is on, the top byte of the address is held, so any carry or borrow stays inside the low 24 bits. A programmable address mask is then ANDed onto every stepped address, whether or not confinement is on.

The count drops by one on every beat. A one-cycle terminal-count pulse marks the beat that leaves the count at zero. In auto-reload mode, that beat instead copies the base address and base count back into the current registers. Bus timing is handled elsewhere.

Top module: `dma_addr_stepper`

## Requirements
- R1: After a clock edge with `rst_n` low, the current address is 0, the current count is 0, `tc_o` is 0 and the address mask is all ones.
- R2: A step with `mode_down_i`=0 and `wide_i`=0 adds 1 to the address.
- R3: A step with `wide_i`=1 changes the address by 2: added when `mode_down_i`=0, subtracted when it is 1.
- R4: A step with `mode_down_i`=1 and `wide_i`=0 subtracts 1 from the address.
- R5: With `wrap_en_i`=1, bits 31:24 of the stepped address equal the old bits 31:24 (before masking), and carry or borrow out of bit 23 is discarded.
- R6: The stepped address is ANDed with the mask, with or without wrap. A cycle with `mask_wr_i`=1 loads `mask_data_i` into the mask, and the new mask takes effect for steps in later cycles.
- R7: Each step decrements the count by one. From zero, the count wraps to all ones and no terminal-count pulse is raised.
- R8: Address and count are updated on the clock edge that samples `step_i`=1. When neither `step_i` nor `load_i` is high, both hold their values.
- R9: `tc_o` is high for exactly the one cycle after the edge on which a step takes the count from 1 to 0.
- R10: With `mode_auto_i`=1, the terminal-count step loads `base_addr_i` and `base_cnt_i` into the current address and count, instead of the stepped values.
- R11: `load_i`=1 copies `base_addr_i` and `base_cnt_i` into the current registers, unmasked. It takes priority over a step in the same cycle, and no terminal-count pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Copy base address and count into current registers |
| base_addr_i | input | ADDR_W | Base address |
| base_cnt_i | input | CNT_W | Base beat count |
| step_i | input | 1 | One beat finished |
| wide_i | input | 1 | 1: 16-bit beat (step 2), 0: 8-bit beat (step 1) |
| mode_down_i | input | 1 | Direction mode bit: 1 decrement, 0 increment |
| mode_auto_i | input | 1 | Auto-reload on terminal count |
| wrap_en_i | input | 1 | Confine address change to the low 24 bits |
| mask_wr_i | input | 1 | Write strobe for the address mask |
| mask_data_i | input | ADDR_W | New address mask |
| cur_addr_o | output | ADDR_W | Current address |
| cur_cnt_o | output | CNT_W | Current count |
| tc_o | output | 1 | Terminal-count pulse |

## Verification
The bench builds the block with a 32-bit address, the top 8 bits frozen under wrap, and an 8-bit count. With the 8-bit count, terminal count, auto-reload and the count wrapping from zero can all be reached in a few beats. The bench also loads addresses next to the bit-23/24 boundary, so the carry or borrow case under wrap is exercised directly and compared with the unconfined case. Narrow masks then show the AND acting on both the wrapped and the unwrapped result.

// File: rtl/dma_step_pkg.sv
// Package: shared beat-size type and step-size helper for the address stepper.
// Assumes byte-addressed memory; a wide beat spans two bytes.
package dma_step_pkg;

    typedef enum logic {
        BEAT_NARROW = 1'b0,
        BEAT_WIDE   = 1'b1
    } beat_kind_e;

    // Number of bytes one beat of the given kind advances the address.
    function automatic logic [1:0] beat_bytes(input beat_kind_e kind);
        return (kind == BEAT_WIDE) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/dma_addr_next.sv
// Module: dma_addr_next
// Computes the stepped address: +/- 1 or 2 bytes, optional freezing of the
// HOLD_W top bits, then AND with the address mask. Purely combinational.
// Assumes HOLD_W < ADDR_W.
module dma_addr_next
    import dma_step_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HOLD_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  beat_kind_e        kind_i,
    input  logic              down_i,
    input  logic              wrap_i,
    output logic [ADDR_W-1:0] next_o
);
    localparam int LOW_W = ADDR_W - HOLD_W;

    logic [ADDR_W-1:0] delta;
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] confined;

    // Step amount widened to the address width, then add or subtract.
    always_comb begin
        delta = {{(ADDR_W-2){1'b0}}, beat_bytes(kind_i)};
        raw   = down_i ? (addr_i - delta) : (addr_i + delta);
    end

    // Variant selected by parameter: freeze the top bits, or no freezing at all.
    generate
        if (HOLD_W > 0) begin : g_hold
            always_comb confined = {addr_i[ADDR_W-1 -: HOLD_W], raw[LOW_W-1:0]};
        end else begin : g_nohold
            always_comb confined = raw;
        end
    endgenerate

    // Select wrap or plain result and apply the mask.
    always_comb next_o = (wrap_i ? confined : raw) & mask_i;

endmodule

// File: rtl/dma_cnt_next.sv
// Module: dma_cnt_next
// Decrements the beat count and flags the beat that ends at zero.
// Combinational; a count of zero wraps to all ones without a flag.
module dma_cnt_next #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] next_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Next count and end-of-block detection.
    always_comb begin
        next_o = cnt_i - ONE;
        last_o = (cnt_i == ONE);
    end

endmodule

// File: rtl/dma_mask_reg.sv
// Module: dma_mask_reg
// Holds the programmable address mask; resets to all ones (no masking).
// Synchronous active-low reset.
module dma_mask_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] data_i,
    output logic [ADDR_W-1:0] mask_o
);
    // Mask register: reset open, overwritten on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= '1;
        else if (wr_i) mask_o <= data_i;
    end

endmodule

// File: rtl/dma_addr_stepper.sv
// Module: dma_addr_stepper (top)
// Current address and count of one DMA channel, advanced once per finished
// beat. Load has priority over step; auto-reload replaces the terminal step.
// Assumes step_i is a one-cycle strobe per beat; bus cycles are elsewhere.
module dma_addr_stepper
    import dma_step_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  base_cnt_i,
    input  logic              step_i,
    input  logic              wide_i,
    input  logic              mode_down_i,
    input  logic              mode_auto_i,
    input  logic              wrap_en_i,
    input  logic              mask_wr_i,
    input  logic [ADDR_W-1:0] mask_data_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  cur_cnt_o,
    output logic              tc_o
);
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] addr_step;
    logic [CNT_W-1:0]  cnt_step;
    logic              cnt_last;
    beat_kind_e        kind;

    // Beat width input mapped onto the shared type.
    always_comb kind = wide_i ? BEAT_WIDE : BEAT_NARROW;

    dma_mask_reg #(.ADDR_W(ADDR_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mask_wr_i),
        .data_i (mask_data_i),
        .mask_o (mask_q)
    );

    dma_addr_next #(.ADDR_W(ADDR_W), .HOLD_W(HOLD_W)) u_anext (
        .addr_i (cur_addr_o),
        .mask_i (mask_q),
        .kind_i (kind),
        .down_i (mode_down_i),
        .wrap_i (wrap_en_i),
        .next_o (addr_step)
    );

    dma_cnt_next #(.CNT_W(CNT_W)) u_cnext (
        .cnt_i  (cur_cnt_o),
        .next_o (cnt_step),
        .last_o (cnt_last)
    );

    // Current address/count update and terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_o <= '0;
            cur_cnt_o  <= '0;
            tc_o       <= 1'b0;
        end else if (load_i) begin
            cur_addr_o <= base_addr_i;
            cur_cnt_o  <= base_cnt_i;
            tc_o       <= 1'b0;
        end else if (step_i) begin
            tc_o <= cnt_last;
            if (cnt_last && mode_auto_i) begin
                cur_addr_o <= base_addr_i;
                cur_cnt_o  <= base_cnt_i;
            end else begin
                cur_addr_o <= addr_step;
                cur_cnt_o  <= cnt_step;
            end
        end else begin
            tc_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_addr_stepper_chk.sv
// Module: dma_addr_stepper_chk
// Port-level properties of the address stepper. Keeps its own copy of the
// mask from the write port so mask-dependent checks need no internals.
module dma_addr_stepper_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic [CNT_W-1:0]  base_cnt_i,
    input logic              step_i,
    input logic              wide_i,
    input logic              mode_down_i,
    input logic              mode_auto_i,
    input logic              wrap_en_i,
    input logic              mask_wr_i,
    input logic [ADDR_W-1:0] mask_data_i,
    input logic [ADDR_W-1:0] cur_addr_o,
    input logic [CNT_W-1:0]  cur_cnt_o,
    input logic              tc_o
);
    localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] mask_seen;

    // Shadow of the mask as written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_seen <= '1;
        else if (mask_wr_i) mask_seen <= mask_data_i;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cur_addr_o == '0 && cur_cnt_o == '0 && !tc_o));

    // R2
    inc_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !mode_auto_i && !wide_i && !mode_down_i && !wrap_en_i && mask_seen == '1)
        |=> cur_addr_o == $past(cur_addr_o) + 1);

    // R3
    wide_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !mode_auto_i && wide_i && !mode_down_i && !wrap_en_i && mask_seen == '1)
        |=> cur_addr_o == $past(cur_addr_o) + 2);

    // R4
    dec_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !mode_auto_i && !wide_i && mode_down_i && !wrap_en_i && mask_seen == '1)
        |=> cur_addr_o == $past(cur_addr_o) - 1);

    // R5
    wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !mode_auto_i && wrap_en_i)
        |=> cur_addr_o[ADDR_W-1 -: HOLD_W] ==
            ($past(cur_addr_o[ADDR_W-1 -: HOLD_W]) & $past(mask_seen[ADDR_W-1 -: HOLD_W])));

    // R6
    mask_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !(mode_auto_i && cur_cnt_o == C_ONE))
        |=> (cur_addr_o & ~$past(mask_seen)) == '0);

    // R7
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !mode_auto_i) |=> cur_cnt_o == $past(cur_cnt_o) - C_ONE);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> ($stable(cur_addr_o) && $stable(cur_cnt_o) && !tc_o));

    // R9
    tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cur_cnt_o == C_ONE) |=> tc_o);

    // R9
    tc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_i && !load_i && cur_cnt_o == C_ONE) |=> !tc_o);

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && mode_auto_i && cur_cnt_o == C_ONE)
        |=> (cur_addr_o == $past(base_addr_i) && cur_cnt_o == $past(base_cnt_i)));

    // R11
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cur_addr_o == $past(base_addr_i) && cur_cnt_o == $past(base_cnt_i) && !tc_o));

endmodule

bind dma_addr_stepper dma_addr_stepper_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)
) u_chk (.*);

// File: tb/dma_addr_stepper_tb.sv
// Directed bench for dma_addr_stepper: one task per scenario.
module dma_addr_stepper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic [CW-1:0] base_cnt_i = '0;
    logic          step_i = 1'b0;
    logic          wide_i = 1'b0;
    logic          mode_down_i = 1'b0;
    logic          mode_auto_i = 1'b0;
    logic          wrap_en_i = 1'b0;
    logic          mask_wr_i = 1'b0;
    logic [AW-1:0] mask_data_i = '0;
    logic [AW-1:0] cur_addr_o;
    logic [CW-1:0] cur_cnt_o;
    logic          tc_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_stepper #(.ADDR_W(AW), .CNT_W(CW), .HOLD_W(8)) u_dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at negedge; result visible at the following negedge.
    task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c);
        base_addr_i = a; base_cnt_i = c; load_i = 1'b1;
        @(negedge clk); load_i = 1'b0;
    endtask

    task automatic step(input logic wide, input logic down, input logic wrap);
        wide_i = wide; mode_down_i = down; wrap_en_i = wrap; step_i = 1'b1;
        @(negedge clk); step_i = 1'b0;
    endtask

    task automatic write_mask(input logic [AW-1:0] m);
        mask_data_i = m; mask_wr_i = 1'b1;
        @(negedge clk); mask_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 addr", cur_addr_o, 0);
        check("R1 cnt", cur_cnt_o, 0);
        check("R1 tc", tc_o, 0);
        load(32'hFFFF_FFFF, 8'd9);
        step(1'b0, 1'b0, 1'b0);
        check("R1 mask open", cur_addr_o, 0);
    endtask

    task automatic t_steps();
        load(32'h0000_1000, 8'd5);
        check("R11 load addr", cur_addr_o, 32'h1000);
        check("R11 load cnt", cur_cnt_o, 5);
        step(1'b0, 1'b0, 1'b0);
        check("R2 inc narrow", cur_addr_o, 32'h1001);
        check("R7 cnt dec", cur_cnt_o, 4);
        step(1'b1, 1'b0, 1'b0);
        check("R3 inc wide", cur_addr_o, 32'h1003);
        step(1'b0, 1'b1, 1'b0);
        check("R4 dec narrow", cur_addr_o, 32'h1002);
        step(1'b1, 1'b1, 1'b0);
        check("R3 dec wide", cur_addr_o, 32'h1000);
        check("R7 cnt after 4", cur_cnt_o, 1);
    endtask

    task automatic t_hold();
        repeat (3) @(negedge clk);
        check("R8 hold addr", cur_addr_o, 32'h1000);
        check("R8 hold cnt", cur_cnt_o, 1);
        check("R8 no tc", tc_o, 0);
    endtask

    task automatic t_wrap();
        load(32'h12FF_FFFF, 8'd10);
        step(1'b0, 1'b0, 1'b1);
        check("R5 wrap carry", cur_addr_o, 32'h1200_0000);
        load(32'h12FF_FFFF, 8'd10);
        step(1'b0, 1'b0, 1'b0);
        check("R5 no wrap carry", cur_addr_o, 32'h1300_0000);
        load(32'h3400_0000, 8'd10);
        step(1'b1, 1'b1, 1'b1);
        check("R5 wrap borrow", cur_addr_o, 32'h34FF_FFFE);
    endtask

    task automatic t_mask();
        write_mask(32'h000F_FFFF);
        load(32'h000F_FFFF, 8'd10);
        step(1'b0, 1'b0, 1'b0);
        check("R6 mask plain", cur_addr_o, 32'h0);
        write_mask(32'h00FF_FFFF);
        load(32'h56FF_FFF0, 8'd10);
        step(1'b1, 1'b0, 1'b1);
        check("R6 mask wrap", cur_addr_o, 32'h00FF_FFF2);
        write_mask(32'hFFFF_FFFF);
        load(32'h56FF_FFF0, 8'd10);
        step(1'b1, 1'b0, 1'b1);
        check("R6 mask restored", cur_addr_o, 32'h56FF_FFF2);
    endtask

    task automatic t_tc();
        load(32'h200, 8'd2);
        step(1'b0, 1'b0, 1'b0);
        check("R9 no tc early", tc_o, 0);
        step(1'b0, 1'b0, 1'b0);
        check("R9 tc pulse", tc_o, 1);
        check("R9 cnt zero", cur_cnt_o, 0);
        check("R9 addr stepped", cur_addr_o, 32'h202);
        @(negedge clk);
        check("R9 tc one cycle", tc_o, 0);
        step(1'b0, 1'b0, 1'b0);
        check("R7 cnt wraps", cur_cnt_o, 8'hFF);
        check("R7 no tc on wrap", tc_o, 0);
    endtask

    task automatic t_auto();
        mode_auto_i = 1'b1;
        load(32'h300, 8'd2);
        step(1'b0, 1'b0, 1'b0);
        check("R10 first beat", cur_addr_o, 32'h301);
        step(1'b0, 1'b0, 1'b0);
        check("R10 reload addr", cur_addr_o, 32'h300);
        check("R10 reload cnt", cur_cnt_o, 2);
        check("R10 tc", tc_o, 1);
        mode_auto_i = 1'b0;
    endtask

    task automatic t_load_prio();
        load(32'h400, 8'd1);
        base_addr_i = 32'h500; base_cnt_i = 8'd7;
        load_i = 1'b1; step_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
        check("R11 prio addr", cur_addr_o, 32'h500);
        check("R11 prio cnt", cur_cnt_o, 7);
        check("R11 prio no tc", tc_o, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_steps();
        t_hold();
        t_wrap();
        t_mask();
        t_tc();
        t_auto();
        t_load_prio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule